// File: doc/BRIEF.md
# Padding Mask Stage

This stage sits on the packet stream that a memory-read sequencer produces. It overwrites padded elements with a configured pad value so that later reductions such as sums or maxima do not see arbitrary data. Each packet carries a sideband with the current index of every loop dimension. The stage watches one selected dimension and uses its index to decide which elements to mask.

Elements at the front of the packet are masked while the selected index is zero. Elements past a valid count are masked while the selected index is at its last value. A per-index mode instead looks up a separate valid count for each of the first eight indices of a short dimension. Elements are 1, 2 or 4 bytes wide, and masking always replaces whole elements.

The stage holds one register slice with a valid/ready handshake. It adds one cycle of latency and passes backpressure upstream without losing packets.

Top module: `pad_mask_stage`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is 0.
- R2: When the selected dimension's index is 0, elements 0 to `cfg_left_pad`-1 are replaced. A left pad at or above the element count replaces the whole packet.
- R3: In basic mode (`cfg_per_index`=0), when the selected index equals `cfg_dim_last`, elements with position >= `cfg_right_valid` are replaced. A count of 0 replaces every element.
- R4: In basic mode, at an index that is neither 0 nor `cfg_dim_last`, the packet data passes unchanged. Indices of the other dimensions have no effect.
- R5: `cfg_elem_size` selects the element width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Element e occupies bytes e*w to e*w+w-1. Byte k of a replaced element takes byte k of `cfg_pad_value`, with byte 0 in bits 7:0.
- R6: When `cfg_dim_last` is 0, left and right masking both apply to the same packet.
- R7: In per-index mode, index i < 8 keeps only the elements with position below table entry i, where entry i sits in bits 8i+7:8i of `cfg_valid_tbl`. Indices of 8 or more get no right masking. Left masking at index 0 still applies.
- R8: A packet accepted at a clock edge appears on the outputs right after that edge, and `out_idx` equals the accepted `in_idx`.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and `in_ready` is 0. No packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_elem_size | input | 2 | Element width code |
| cfg_mask_dim | input | 2 | Selected loop dimension |
| cfg_left_pad | input | 8 | Leading elements masked at index 0 |
| cfg_right_valid | input | 8 | Elements kept at the last index (basic mode) |
| cfg_dim_last | input | 8 | Last index value of the selected dimension |
| cfg_per_index | input | 1 | 1 selects the per-index valid-count table |
| cfg_valid_tbl | input | 64 | Eight 8-bit valid counts |
| cfg_pad_value | input | 32 | Replacement element value |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Stage can accept a packet |
| in_data | input | 256 | Input packet bytes, lane 0 in bits 7:0 |
| in_idx | input | 32 | Loop indices, dimension d in bits 8d+7:8d |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Downstream accepts the packet |
| out_data | output | 256 | Masked packet bytes |
| out_idx | output | 32 | Loop indices carried with the packet |

## Verification
The assertions check on every cycle that reset clears the output and that the one-cycle hand-over carries the index sideband. They also check that a stalled output holds steady. In basic mode they check that packets at interior indices leave untouched and that a nonzero left pad writes the pad byte into lane 0. The masking boundaries need the bench's scenarios: exact element counts for each width, pad bytes placed within wide elements, the zero-count and oversize-pad extremes, both sides on one packet, and the per-index table including indices beyond it.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
    localparam int CNT_W = 8;
    localparam int TBL_N = 8;

    typedef enum logic [1:0] {
        ESZ_1B = 2'd0,
        ESZ_2B = 2'd1,
        ESZ_4B = 2'd2
    } esz_e;

    // log2 of the element width in bytes
    function automatic logic [1:0] esz_shift(logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    typedef struct packed {
        logic [1:0]       elem_size;
        logic [CNT_W-1:0] left_pad;
        logic [CNT_W-1:0] right_valid;
        logic [CNT_W-1:0] dim_last;
        logic             per_index;
    } mask_cfg_t;
endpackage

// File: rtl/pmask_lane_keep.sv
module pmask_lane_keep
    import pmask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IDX_W = 8,
    parameter int NDIM  = 4
) (
    input  mask_cfg_t               cfg,
    input  logic [$clog2(NDIM)-1:0] dim,
    input  logic [TBL_N*CNT_W-1:0]  tbl,
    input  logic [NDIM*IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]        sel_idx,
    output logic [LANES-1:0]        keep
);
    localparam int TBL_W = $clog2(TBL_N);

    logic [IDX_W-1:0] idx_a [NDIM];
    logic [CNT_W-1:0] tbl_a [TBL_N];

    for (genvar d = 0; d < NDIM; d++) begin : g_idx
        assign idx_a[d] = idx[d*IDX_W +: IDX_W];
    end
    for (genvar t = 0; t < TBL_N; t++) begin : g_tbl
        assign tbl_a[t] = tbl[t*CNT_W +: CNT_W];
    end

    logic             at_first, apply_right;
    logic [CNT_W-1:0] limit;
    logic [1:0]       sh;

    always_comb begin
        sel_idx  = idx_a[dim];
        sh       = esz_shift(cfg.elem_size);
        at_first = (sel_idx == '0);
        if (cfg.per_index) begin
            apply_right = (sel_idx < IDX_W'(TBL_N));
            limit       = tbl_a[sel_idx[TBL_W-1:0]];
        end else begin
            apply_right = (sel_idx == cfg.dim_last);
            limit       = cfg.right_valid;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CNT_W-1:0] pos;
        assign pos     = CNT_W'(l) >> sh;
        assign keep[l] = !((at_first && pos < cfg.left_pad) ||
                           (apply_right && pos >= limit));
    end
endmodule

// File: rtl/pmask_merge.sv
module pmask_merge
    import pmask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES*8-1:0] data,
    input  logic [LANES-1:0]   keep,
    input  logic [31:0]        pad,
    input  logic [1:0]         elem_size,
    output logic [LANES*8-1:0] merged
);
    logic [7:0] pad_b [4];
    logic [1:0] bmask;

    for (genvar k = 0; k < 4; k++) begin : g_pb
        assign pad_b[k] = pad[8*k +: 8];
    end

    always_comb begin
        case (esz_shift(elem_size))
            2'd1:    bmask = 2'b01;
            2'd2:    bmask = 2'b11;
            default: bmask = 2'b00;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [1:0] bsel;
        assign bsel = 2'(l) & bmask;
        assign merged[8*l +: 8] = keep[l] ? data[8*l +: 8] : pad_b[bsel];
    end
endmodule

// File: rtl/pmask_slice.sv
module pmask_slice #(
    parameter int DW = 256,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic [SW-1:0] in_side,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [SW-1:0] out_side
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
        if (in_valid && in_ready) begin
            out_data <= in_data;
            out_side <= in_side;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_side == $past(in_side)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_side)));
endmodule

// File: rtl/pad_mask_stage.sv
module pad_mask_stage
    import pmask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IDX_W = 8,
    parameter int NDIM  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cfg_elem_size,
    input  logic [$clog2(NDIM)-1:0] cfg_mask_dim,
    input  logic [CNT_W-1:0]        cfg_left_pad,
    input  logic [CNT_W-1:0]        cfg_right_valid,
    input  logic [IDX_W-1:0]        cfg_dim_last,
    input  logic                    cfg_per_index,
    input  logic [TBL_N*CNT_W-1:0]  cfg_valid_tbl,
    input  logic [31:0]             cfg_pad_value,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*8-1:0]      in_data,
    input  logic [NDIM*IDX_W-1:0]   in_idx,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*8-1:0]      out_data,
    output logic [NDIM*IDX_W-1:0]   out_idx
);
    localparam int DW = LANES * 8;
    localparam int SW = NDIM * IDX_W;

    mask_cfg_t        cfg;
    logic [LANES-1:0] keep;
    logic [IDX_W-1:0] sel_idx;
    logic [DW-1:0]    merged;

    always_comb begin
        cfg.elem_size   = cfg_elem_size;
        cfg.left_pad    = cfg_left_pad;
        cfg.right_valid = cfg_right_valid;
        cfg.dim_last    = CNT_W'(cfg_dim_last);
        cfg.per_index   = cfg_per_index;
    end

    pmask_lane_keep #(.LANES(LANES), .IDX_W(IDX_W), .NDIM(NDIM)) u_keep (
        .cfg     (cfg),
        .dim     (cfg_mask_dim),
        .tbl     (cfg_valid_tbl),
        .idx     (in_idx),
        .sel_idx (sel_idx),
        .keep    (keep)
    );

    pmask_merge #(.LANES(LANES)) u_merge (
        .data      (in_data),
        .keep      (keep),
        .pad       (cfg_pad_value),
        .elem_size (cfg_elem_size),
        .merged    (merged)
    );

    pmask_slice #(.DW(DW), .SW(SW)) u_slice (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (merged),
        .in_side   (in_idx),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_side  (out_idx)
    );

    assert_interior_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cfg_per_index && sel_idx != '0 &&
         sel_idx != cfg_dim_last) |=> (out_data == $past(in_data)));

    assert_left_first_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && sel_idx == '0 && cfg_left_pad != '0 &&
         cfg_elem_size == 2'd0) |=> (out_data[7:0] == $past(cfg_pad_value[7:0])));
endmodule

// File: tb/pad_mask_stage_bench.sv
`timescale 1ns/1ps
module pad_mask_stage_bench;
    typedef struct packed {
        logic [1:0]  esz;
        logic [1:0]  dim;
        logic [7:0]  lpad;
        logic [7:0]  rval;
        logic        perx;
        logic [7:0]  sidx;
        logic [7:0]  last;
        logic [31:0] pad;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    // one row per scenario; expected data comes from model() below
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 8'd2,  8'd28, 1'b0, 8'd0, 8'd2, 32'h0,        4'd2}, // R2 first packet of row
        '{2'd0, 2'd1, 8'd2,  8'd28, 1'b0, 8'd1, 8'd2, 32'h0,        4'd4}, // R4 middle packet
        '{2'd0, 2'd1, 8'd2,  8'd28, 1'b0, 8'd2, 8'd2, 32'h0,        4'd3}, // R3 last packet
        '{2'd1, 2'd0, 8'd3,  8'd0,  1'b0, 8'd0, 8'd5, 32'h0000BEEF, 4'd5}, // R5 halfword left
        '{2'd2, 2'd2, 8'd1,  8'd5,  1'b0, 8'd7, 8'd7, 32'hA5B6C7D8, 4'd5}, // R5 word right
        '{2'd0, 2'd3, 8'd4,  8'd20, 1'b0, 8'd0, 8'd0, 32'h11,       4'd6}, // R6 both sides
        '{2'd0, 2'd1, 8'd0,  8'd0,  1'b0, 8'd3, 8'd3, 32'h5A,       4'd3}, // R3 zero count
        '{2'd1, 2'd2, 8'd0,  8'd0,  1'b1, 8'd6, 8'd0, 32'h0,        4'd7}, // R7 entry 6 = 1
        '{2'd1, 2'd2, 8'd0,  8'd0,  1'b1, 8'd7, 8'd0, 32'h3C3C,     4'd7}, // R7 entry 7 = 0
        '{2'd1, 2'd2, 8'd2,  8'd0,  1'b1, 8'd0, 8'd0, 32'h7E7E,     4'd7}, // R7 left at index 0
        '{2'd1, 2'd2, 8'd0,  8'd0,  1'b1, 8'd9, 8'd0, 32'hFFFF,     4'd7}, // R7 beyond table
        '{2'd0, 2'd0, 8'd40, 8'd32, 1'b0, 8'd0, 8'd4, 32'h99,       4'd2}, // R2 oversize pad
        '{2'd2, 2'd1, 8'd0,  8'd0,  1'b0, 8'd4, 8'd9, 32'hDEAD,     4'd4}  // R4 word, interior
    };
    localparam int TBL [8] = '{16, 16, 16, 16, 16, 16, 1, 0};

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   cfg_elem_size;
    logic [1:0]   cfg_mask_dim;
    logic [7:0]   cfg_left_pad, cfg_right_valid, cfg_dim_last;
    logic         cfg_per_index;
    logic [63:0]  cfg_valid_tbl;
    logic [31:0]  cfg_pad_value;
    logic         in_valid, in_ready, out_valid, out_ready;
    logic [255:0] in_data, out_data;
    logic [31:0]  in_idx, out_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pad_mask_stage u_pad_mask_stage (
        .clk(clk), .rst(rst), .cfg_elem_size(cfg_elem_size),
        .cfg_mask_dim(cfg_mask_dim), .cfg_left_pad(cfg_left_pad),
        .cfg_right_valid(cfg_right_valid), .cfg_dim_last(cfg_dim_last),
        .cfg_per_index(cfg_per_index), .cfg_valid_tbl(cfg_valid_tbl),
        .cfg_pad_value(cfg_pad_value), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_idx(in_idx), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx)
    );

    function automatic logic [255:0] model(logic [255:0] d, vec_t v);
        logic [255:0] r;
        for (int l = 0; l < 32; l++) begin
            int eb = 1 << v.esz;
            int e = l / eb;
            bit m;
            m = (v.sidx == 0 && e < int'(v.lpad)) ||
                (!v.perx && v.sidx == v.last && e >= int'(v.rval)) ||
                (v.perx && v.sidx < 8 && e >= TBL[v.sidx[2:0]]);
            r[8*l +: 8] = m ? v.pad[8*(l % eb) +: 8] : d[8*l +: 8];
        end
        return r;
    endfunction

    function automatic logic [255:0] pattern(int seed);
        logic [255:0] p;
        for (int l = 0; l < 32; l++) p[8*l +: 8] = 8'(8'h80 + l + 3 * seed);
        return p;
    endfunction

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(vec_t v);
        cfg_elem_size   = v.esz;
        cfg_mask_dim    = v.dim;
        cfg_left_pad    = v.lpad;
        cfg_right_valid = v.rval;
        cfg_per_index   = v.perx;
        cfg_dim_last    = v.last;
        cfg_pad_value   = v.pad;
    endtask

    // index sideband: selected dimension holds sidx, others hold 0
    function automatic logic [31:0] make_idx(vec_t v);
        logic [31:0] x = '0;
        x[8*v.dim +: 8] = v.sidx;
        return x;
    endfunction

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] exp_d;
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        in_data = '0;
        in_idx = '0;
        apply_cfg(VECS[0]);
        for (int t = 0; t < 8; t++) cfg_valid_tbl[8*t +: 8] = 8'(TBL[t]);
        repeat (3) @(negedge clk);
        check(!out_valid, "R1", 256'(out_valid), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1", 256'({out_valid, in_ready}), 256'(1));

        for (int i = 0; i < NV; i++) begin
            apply_cfg(VECS[i]);
            in_data  = pattern(i);
            in_idx   = make_idx(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            exp_d = model(pattern(i), VECS[i]);
            check(out_valid && out_data == exp_d,
                  $sformatf("R%0d vec%0d", VECS[i].req, i), out_data, exp_d);
            check(out_idx == make_idx(VECS[i]), "R8 sideband",
                  256'(out_idx), 256'(make_idx(VECS[i])));
        end

        // R4: other dimensions' indices do not matter
        apply_cfg(VECS[1]);
        in_data  = pattern(20);
        in_idx   = 32'hFF00_0100 | 32'h0000_00F0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_data == pattern(20), "R4 other dims", out_data, pattern(20));

        // R9: stall holds A, B waits, then B follows; nothing lost
        @(negedge clk);
        out_ready = 1'b0;
        apply_cfg(VECS[1]);
        in_idx   = make_idx(VECS[1]);
        in_data  = pattern(30);
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid && out_data == pattern(30), "R8 accept A", out_data, pattern(30));
        in_data = pattern(31);
        repeat (2) @(negedge clk);
        check(out_valid && out_data == pattern(30) && !in_ready, "R9 hold",
              out_data, pattern(30));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_data == pattern(31), "R9 next", out_data, pattern(31));
        @(negedge clk);
        check(!out_valid, "R9 drain", 256'(out_valid), 256'(0));

        // R1: reset while holding a packet clears valid
        in_valid  = 1'b1;
        in_data   = pattern(40);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid, "R1 mid-run", 256'(out_valid), 256'(0));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule